// File: doc/BRIEF.md
# Receive Holding Queue with Error Status and Flow Control

This block sits behind a serial receiver on one channel. Each finished character enters a small first-in first-out queue together with three flags: framing error, parity error and received break. The CPU sees the oldest character at the head of the queue and removes it with a pop strobe.

The flags can be reported in two ways. In per-character mode they belong only to the head character. In accumulated mode they are a sticky OR over every character that has become the head since the last error-clear command. The block also raises a ready indication, a full indication and an interrupt request. The interrupt source is either ready or full, picked by a select bit.

An active-low request-to-send line follows a software bit. When automatic flow control is on, a start bit that arrives while the queue is full forces the line inactive. The line becomes active again once a slot is free, and the software bit is never changed.

Top module: `rx_status_fifo`

## Requirements
- R1: The queue holds up to DEPTH (default 3) characters in arrival order. `headData` shows the oldest one. `rxReady` is high while at least one character is held, and `fifoFull` is high while DEPTH are held. Reset empties the queue and clears `overrun`.
- R2: A high `popReq` removes the head character at the clock edge. A pop while the queue is empty has no effect.
- R3: When `blockErrMode` is 0, `stFrameErr`, `stParErr` and `stBrk` equal the flags stored with the head character. All three are 0 while the queue is empty.
- R4: When `blockErrMode` is 1, the three status outputs are the OR of the flags of every character that became the head since the last `errClear`. A character becomes the head when it is written into an empty queue, or when the entry in front of it is popped.
- R5: `errClear` clears the accumulated flags and `overrun` at the clock edge. A character that becomes the head at that same edge still contributes its flags.
- R6: A character loaded while the queue is full, with no pop in the same cycle, is discarded and sets `overrun`. A load and a pop in the same cycle on a full queue are both accepted.
- R7: `irqReq` follows `rxReady` when `irqSelFull` is 0 and follows `fifoFull` when it is 1.
- R8: Without an automatic hold, `rtsN` is the inverse of `swRts`.
- R9: With `autoRtsEn` set, a `rxStartDet` pulse while the queue is full, with no pop in that cycle, drives `rtsN` high from the next cycle. `rtsN` returns to the inverse of `swRts` at the edge where the count drops below DEPTH.
- R10: A `rxStartDet` pulse has no effect on `rtsN` when `autoRtsEn` is 0 or when the queue is not full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rxData | input | DATA_W | Received character |
| rxFrameErr | input | 1 | Framing error flag of the incoming character |
| rxParErr | input | 1 | Parity error flag of the incoming character |
| rxBrk | input | 1 | Break flag of the incoming character |
| rxLoad | input | 1 | Write strobe for a completed character |
| rxStartDet | input | 1 | Pulse when the receiver sees a valid start bit |
| popReq | input | 1 | CPU read of the head character |
| errClear | input | 1 | Error-clear command |
| swRts | input | 1 | Software request-to-send bit |
| autoRtsEn | input | 1 | Enables automatic request-to-send negation |
| irqSelFull | input | 1 | 0: interrupt on ready, 1: interrupt on full |
| blockErrMode | input | 1 | 0: per-character flags, 1: accumulated flags |
| headData | output | DATA_W | Character at the head of the queue |
| stFrameErr | output | 1 | Reported framing error |
| stParErr | output | 1 | Reported parity error |
| stBrk | output | 1 | Reported break |
| rxReady | output | 1 | At least one character held |
| fifoFull | output | 1 | Queue full |
| irqReq | output | 1 | Interrupt request |
| overrun | output | 1 | A character was lost |
| rtsN | output | 1 | Request-to-send, active low |

## Verification
Two events can meet at one clock edge: a load and a pop on a queue that is full or holds one entry, and an error-clear together with a change of head character. The table drives these pairs in single cycles. The bench checks that nothing is lost or falsely flagged as overrun, and that the incoming head's flags survive the clear. Start-bit pulses are also placed on a full queue and on one that a pop is draining, and the bench checks that `rtsN` rises only in the held case.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  typedef struct packed {
    logic frame;
    logic parity;
    logic brk;
  } rx_err_t;

  typedef struct packed {
    logic push;
    logic pop;
    logic clrErr;
    logic headEvent;
    logic headFromIn;
    logic hasData;
  } rxq_strobe_t;

endpackage

// File: rtl/rxq_control.sv
module rxq_control
  import rxq_pkg::*;
#(
  parameter int DEPTH = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rxLoad,
  input  logic        rxStartDet,
  input  logic        popReq,
  input  logic        errClear,
  input  logic        swRts,
  input  logic        autoRtsEn,
  input  logic        irqSelFull,
  output rxq_strobe_t strb,
  output logic        rxReady,
  output logic        fifoFull,
  output logic        irqReq,
  output logic        overrun,
  output logic        rtsN
);

  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] ONE_CNT  = CNT_W'(1);

  logic [CNT_W-1:0] count, countNext;
  logic canPop, canPush, fromIn, autoHold;

  assign rxReady  = (count != '0);
  assign fifoFull = (count == FULL_CNT);
  assign canPop   = popReq && rxReady;
  assign canPush  = rxLoad && (!fifoFull || canPop);
  assign fromIn   = canPush && (!rxReady || (canPop && count == ONE_CNT));

  always_comb begin
    countNext = count;
    if (canPush && !canPop) countNext = count + ONE_CNT;
    else if (!canPush && canPop) countNext = count - ONE_CNT;
  end

  always_comb begin
    strb.push       = canPush;
    strb.pop        = canPop;
    strb.clrErr     = errClear;
    strb.headFromIn = fromIn;
    strb.headEvent  = fromIn || (canPop && count > ONE_CNT);
    strb.hasData    = rxReady;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count    <= '0;
      overrun  <= 1'b0;
      autoHold <= 1'b0;
    end else begin
      count    <= countNext;
      overrun  <= (overrun && !errClear) || (rxLoad && !canPush);
      autoHold <= autoRtsEn && (countNext == FULL_CNT) &&
                  (autoHold || (rxStartDet && fifoFull));
    end
  end

  assign irqReq = irqSelFull ? fifoFull : rxReady;
  assign rtsN   = !(swRts && !autoHold);

  // R1
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL_CNT);

  // R6
  overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rxLoad && fifoFull && !popReq) |=> overrun);

  // R9
  rts_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (autoRtsEn && rxStartDet && fifoFull && !popReq) |=> rtsN);

endmodule

// File: rtl/rxq_datapath.sv
module rxq_datapath
  import rxq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  rxq_strobe_t       strb,
  input  logic [DATA_W-1:0] inData,
  input  rx_err_t           inErr,
  input  logic              blockMode,
  output logic [DATA_W-1:0] headData,
  output rx_err_t           reportErr
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);

  typedef struct packed {
    logic [DATA_W-1:0] data;
    rx_err_t           err;
  } slot_t;

  slot_t            slots [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr, rdNext;
  rx_err_t          accum, newHeadErr;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == LAST_IDX) ? '0 : p + PTR_W'(1);
  endfunction

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) slots[i] <= '0;
      else if (strb.push && wrPtr == PTR_W'(i)) slots[i] <= '{data: inData, err: inErr};
    end
  end

  assign rdNext     = bump(rdPtr);
  assign newHeadErr = strb.headFromIn ? inErr : slots[rdNext].err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrPtr <= '0;
      rdPtr <= '0;
      accum <= '0;
    end else begin
      if (strb.push) wrPtr <= bump(wrPtr);
      if (strb.pop)  rdPtr <= rdNext;
      accum <= (strb.clrErr ? rx_err_t'('0) : accum) |
               (strb.headEvent ? newHeadErr : rx_err_t'('0));
    end
  end

  assign headData  = slots[rdPtr].data;
  assign reportErr = blockMode ? accum :
                     (strb.hasData ? slots[rdPtr].err : rx_err_t'('0));

  // R2
  pop_needs_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb.pop |-> strb.hasData);

  // R4
  accum_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.clrErr |=> ((accum & $past(accum)) == $past(accum)));

endmodule

// File: rtl/rx_status_fifo.sv
module rx_status_fifo
  import rxq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] rxData,
  input  logic              rxFrameErr,
  input  logic              rxParErr,
  input  logic              rxBrk,
  input  logic              rxLoad,
  input  logic              rxStartDet,
  input  logic              popReq,
  input  logic              errClear,
  input  logic              swRts,
  input  logic              autoRtsEn,
  input  logic              irqSelFull,
  input  logic              blockErrMode,
  output logic [DATA_W-1:0] headData,
  output logic              stFrameErr,
  output logic              stParErr,
  output logic              stBrk,
  output logic              rxReady,
  output logic              fifoFull,
  output logic              irqReq,
  output logic              overrun,
  output logic              rtsN
);

  rxq_strobe_t strb;
  rx_err_t     inErr, repErr;

  assign inErr = '{frame: rxFrameErr, parity: rxParErr, brk: rxBrk};

  rxq_control #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .rxLoad(rxLoad), .rxStartDet(rxStartDet),
    .popReq(popReq), .errClear(errClear), .swRts(swRts), .autoRtsEn(autoRtsEn),
    .irqSelFull(irqSelFull), .strb(strb), .rxReady(rxReady), .fifoFull(fifoFull),
    .irqReq(irqReq), .overrun(overrun), .rtsN(rtsN)
  );

  rxq_datapath #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .inData(rxData), .inErr(inErr),
    .blockMode(blockErrMode), .headData(headData), .reportErr(repErr)
  );

  assign stFrameErr = repErr.frame;
  assign stParErr   = repErr.parity;
  assign stBrk      = repErr.brk;

endmodule

// File: tb/rx_status_fifo_bench.sv
module rx_status_fifo_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] rxData = '0;
  logic rxFrameErr = 0, rxParErr = 0, rxBrk = 0, rxLoad = 0, rxStartDet = 0;
  logic popReq = 0, errClear = 0, swRts = 0, autoRtsEn = 0, irqSelFull = 0, blockErrMode = 0;
  logic [7:0] headData;
  logic stFrameErr, stParErr, stBrk, rxReady, fifoFull, irqReq, overrun, rtsN;

  int nRun = 0, nFail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  rx_status_fifo u_rx_status_fifo (
    .clk(clk), .rst_n(rst_n), .rxData(rxData), .rxFrameErr(rxFrameErr),
    .rxParErr(rxParErr), .rxBrk(rxBrk), .rxLoad(rxLoad), .rxStartDet(rxStartDet),
    .popReq(popReq), .errClear(errClear), .swRts(swRts), .autoRtsEn(autoRtsEn),
    .irqSelFull(irqSelFull), .blockErrMode(blockErrMode), .headData(headData),
    .stFrameErr(stFrameErr), .stParErr(stParErr), .stBrk(stBrk), .rxReady(rxReady),
    .fifoFull(fifoFull), .irqReq(irqReq), .overrun(overrun), .rtsN(rtsN)
  );

  typedef struct packed {
    logic ld; logic [7:0] din; logic fe, pe, bk;
    logic pop, clr, st, sw, au, isel, blk;
    logic rdy, full, irq, rts, ovr; logic [7:0] dat; logic efe, epe, ebk;
  } vec_t;

  localparam int NV = 22;
  //  ld din    fe pe bk pop clr st sw au is bk | rdy full irq rts ovr dat   fe pe bk
  localparam vec_t VEC [NV] = '{
    '{1, 'hA1, 1, 0, 0, 0, 0, 0, 1, 1, 0, 0,  1, 0, 1, 0, 0, 'hA1, 1, 0, 0},
    '{1, 'hB2, 0, 1, 0, 0, 0, 0, 1, 1, 0, 0,  1, 0, 1, 0, 0, 'hA1, 1, 0, 0},
    '{1, 'hC3, 0, 0, 1, 0, 0, 0, 1, 1, 1, 0,  1, 1, 1, 0, 0, 'hA1, 1, 0, 0},
    '{0, 'h00, 0, 0, 0, 0, 0, 1, 1, 1, 1, 0,  1, 1, 1, 1, 0, 'hA1, 1, 0, 0},
    '{1, 'hD4, 0, 0, 0, 0, 0, 0, 1, 1, 1, 0,  1, 1, 1, 1, 1, 'hA1, 1, 0, 0},
    '{0, 'h00, 0, 0, 0, 1, 0, 0, 1, 1, 1, 0,  1, 0, 0, 0, 1, 'hB2, 0, 1, 0},
    '{0, 'h00, 0, 0, 0, 0, 0, 0, 1, 1, 0, 1,  1, 0, 1, 0, 1, 'hB2, 1, 1, 0},
    '{0, 'h00, 0, 0, 0, 1, 0, 0, 1, 1, 0, 1,  1, 0, 1, 0, 1, 'hC3, 1, 1, 1},
    '{0, 'h00, 0, 0, 0, 0, 1, 0, 1, 1, 0, 1,  1, 0, 1, 0, 0, 'hC3, 0, 0, 0},
    '{1, 'hE5, 0, 1, 0, 1, 0, 0, 1, 1, 0, 1,  1, 0, 1, 0, 0, 'hE5, 0, 1, 0},
    '{1, 'hF6, 1, 0, 0, 1, 1, 0, 1, 1, 0, 1,  1, 0, 1, 0, 0, 'hF6, 1, 0, 0},
    '{0, 'h00, 0, 0, 0, 0, 0, 0, 1, 1, 0, 0,  1, 0, 1, 0, 0, 'hF6, 1, 0, 0},
    '{1, 'h77, 0, 0, 0, 0, 0, 0, 1, 1, 0, 0,  1, 0, 1, 0, 0, 'hF6, 1, 0, 0},
    '{1, 'h88, 0, 0, 0, 0, 0, 0, 1, 1, 0, 0,  1, 1, 1, 0, 0, 'hF6, 1, 0, 0},
    '{0, 'h00, 0, 0, 0, 0, 0, 1, 1, 0, 0, 0,  1, 1, 1, 0, 0, 'hF6, 1, 0, 0},
    '{1, 'h99, 0, 0, 0, 1, 0, 0, 1, 1, 0, 0,  1, 1, 1, 0, 0, 'h77, 0, 0, 0},
    '{0, 'h00, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0,  1, 1, 1, 1, 0, 'h77, 0, 0, 0},
    '{0, 'h00, 0, 0, 0, 1, 0, 0, 1, 1, 0, 0,  1, 0, 1, 0, 0, 'h88, 0, 0, 0},
    '{0, 'h00, 0, 0, 0, 0, 0, 1, 1, 1, 0, 0,  1, 0, 1, 0, 0, 'h88, 0, 0, 0},
    '{0, 'h00, 0, 0, 0, 1, 0, 0, 1, 1, 0, 0,  1, 0, 1, 0, 0, 'h99, 0, 0, 0},
    '{0, 'h00, 0, 0, 0, 1, 0, 0, 1, 1, 0, 0,  0, 0, 0, 0, 0, 'h00, 0, 0, 0},
    '{0, 'h00, 0, 0, 0, 1, 0, 0, 1, 1, 0, 0,  0, 0, 0, 0, 0, 'h00, 0, 0, 0}
  };

  function automatic string vecTag(input int i);
    case (i)
      0, 1, 2, 12, 13: return "R1";
      3:               return "R9";
      4, 15:           return "R6";
      5:               return "R7 R9";
      6, 7, 9:         return "R4";
      8, 10:           return "R5";
      11, 20:          return "R3";
      14, 18:          return "R10";
      16:              return "R8";
      default:         return "R2";
    endcase
  endfunction

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    nRun++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // packed as {rdy, full, irq, rts, ovr, fe, pe, bk, data}
  function automatic logic [15:0] observed(input logic withData);
    return {rxReady, fullBit(), irqReq, rtsN, overrun, stFrameErr, stParErr, stBrk,
            withData ? headData : 8'h00};
  endfunction

  function automatic logic fullBit();
    return fifoFull;
  endfunction

  initial begin
    #(20 * 200000);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    // reset state, R1 and R8 (swRts low gives rtsN high)
    repeat (3) @(negedge clk);
    check("R1", observed(1'b0), 16'hF000 & 16'h1000);
    @(negedge clk) rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      rxLoad = VEC[i].ld; rxData = VEC[i].din;
      rxFrameErr = VEC[i].fe; rxParErr = VEC[i].pe; rxBrk = VEC[i].bk;
      popReq = VEC[i].pop; errClear = VEC[i].clr; rxStartDet = VEC[i].st;
      swRts = VEC[i].sw; autoRtsEn = VEC[i].au;
      irqSelFull = VEC[i].isel; blockErrMode = VEC[i].blk;
      @(posedge clk);
      #5;
      check(vecTag(i), observed(VEC[i].rdy),
            {VEC[i].rdy, VEC[i].full, VEC[i].irq, VEC[i].rts, VEC[i].ovr,
             VEC[i].efe, VEC[i].epe, VEC[i].ebk, VEC[i].rdy ? VEC[i].dat : 8'h00});
    end

    // R6 then reset mid-run: fill, overrun, reset clears everything (R1)
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      rxLoad = 1'b1; rxData = 8'(8'h30 + k); popReq = 1'b0; errClear = 1'b0;
      rxStartDet = 1'b0; blockErrMode = 1'b0; rxFrameErr = 1'b0; rxParErr = 1'b0; rxBrk = 1'b0;
    end
    @(negedge clk) rxLoad = 1'b0;
    check("R6", observed(1'b1), {5'b11101, 3'b000, 8'h30});
    rst_n = 1'b0;
    #1;
    check("R1", observed(1'b0), {5'b00000, 3'b000, 8'h00});
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    check("R8", {15'd0, rtsN}, 16'h0000);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule